// File: doc/BRIEF.md
# Fault Status Register with Shared Alert Line

This block collects fault events from a battery protection controller into an 8-bit status register. It drives a shared, active-high alert line that is high whenever any status bit is pending. The host clears pending bits by writing ones to the register. Once the last bit is cleared, the alert line falls by itself.

The alert line is wired-OR with outside sources, such as a secondary protector. The block therefore senses the line level as well as driving it. When the block drives low and the line reads high, something external has raised it. The block records this as an override fault in the top status bit and turns off both the charge and discharge switch enables at once. The switches stay off until the host clears the override bit and then re-enables them through a separate control write. An outside high cannot be told apart from the block's own high while the block is driving. Detection is therefore blanked while the block drives high and for one cycle after its drive falls.

Top module: `fault_alert_ctrl`

## Requirements
- R1: `alert_o` is 1 in exactly the cycles where at least one bit of `status_o` is 1.
- R2: A write with `wr_sel_i` = 0 clears every status bit whose position holds 1 in `wr_data_i`, taking effect at the next clock edge. Bits at positions that hold 0 keep their value.
- R3: A one-cycle pulse on `fault_set_i[k]` (k = 0..6) sets `status_o[k]` at the next edge. If the same bit is written with a 1 in the same cycle, the bit still ends up set.
- R4: When the last pending bit is cleared by a write, `alert_o` returns to 0 in the same cycle that `status_o` becomes zero, with no other command.
- R5: The line `alert_line_i` passes through a two-flop synchronizer. If it is high in cycle m while `alert_o` is 0 in cycles m-1 and m, `status_o[7]` (override) reads 1 from the third clock edge after cycle m's sample.
- R6: In the cycle where `status_o[7]` first reads 1, both `chg_en_o` and `dsg_en_o` read 0. They read 0 for as long as bit 7 stays set.
- R7: A high line in a cycle where `alert_o` is 1, or in the first cycle after `alert_o` falls, never sets `status_o[7]`.
- R8: A write with `wr_sel_i` = 1 loads `chg_en_o` from `wr_data_i[0]` and `dsg_en_o` from `wr_data_i[1]` at the next edge. The write is ignored while `status_o[7]` is 1.
- R9: During and right after reset, `status_o` is 0, `alert_o` is 0 and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_set_i | input | 7 | One-cycle set pulses for status bits 6..0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = status (write-one-clear), 1 = switch control |
| wr_data_i | input | 8 | Write data |
| alert_line_i | input | 1 | Sensed level of the shared alert line |
| alert_o | output | 1 | Alert drive, high when any status bit is set |
| status_o | output | 8 | Status register; bit 7 is the external override fault |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |

## Verification
The bench targets the cycle where the block's own drive has just fallen while the line is still high. A design without the blank window would latch a false override there and drop both switches. It also raises a fault pulse and a write-one clear on the same bit together; a design that favours the clear would lose the fault. It tries to re-enable the switches while the override is still pending; a design that accepts that write would let current flow through an unresolved fault. A long pseudo-random run of pulses, writes and external highs is compared cycle by cycle against a behavioural model.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam int STATUS_W     = 8;
    localparam int OVR_BIT      = STATUS_W - 1;
    localparam int SYNC_STAGES  = 2;
    localparam int BLANK_CYCLES = 1;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CTRL   = 1'b1
    } wr_target_e;

endpackage

// File: rtl/fsa_line_sense.sv
module fsa_line_sense #(
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_i,
    input  logic line_i,
    output logic ovr_det_o
);

    localparam int HIST_W = SYNC_STAGES + BLANK_CYCLES;
    localparam logic [HIST_W-1:0] WIN_MASK =
        HIST_W'(((1 << (BLANK_CYCLES + 1)) - 1) << (SYNC_STAGES - 1));

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [HIST_W-1:0]      hist;
    } sense_t;

    sense_t sense_d, sense_q;

    always_comb begin
        sense_d         = sense_q;
        sense_d.sync[0] = line_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sense_d.sync[i] = sense_q.sync[i-1];
        end
        sense_d.hist[0] = drive_i;
        for (int i = 1; i < HIST_W; i++) begin
            sense_d.hist[i] = sense_q.hist[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
        end else begin
            sense_q <= sense_d;
        end
    end

    // Synchronized sample is compared with the drive of the same age, and
    // the window also covers the cycle before it.
    assign ovr_det_o = sense_q.sync[SYNC_STAGES-1] & ~(|(sense_q.hist & WIN_MASK));

endmodule

// File: rtl/fsa_status_reg.sv
module fsa_status_reg
    import fsa_pkg::*;
#(
    parameter int STATUS_W = 8,
    parameter int OVR_BIT  = STATUS_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OVR_BIT-1:0]  fault_set_i,
    input  logic                ovr_det_i,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [STATUS_W-1:0] wr_data_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                alert_o
);

    typedef struct packed {
        logic [STATUS_W-1:0] bits;
    } stat_t;

    stat_t               stat_d, stat_q;
    logic [STATUS_W-1:0] clr_mask;
    logic [STATUS_W-1:0] set_vec;

    assign clr_mask = (wr_en_i && (wr_sel_i == SEL_STATUS)) ? wr_data_i : '0;

    generate
        for (genvar k = 0; k < STATUS_W; k++) begin : g_set_map
            if (k == OVR_BIT) begin : g_ovr
                assign set_vec[k] = ovr_det_i;
            end else begin : g_fault
                assign set_vec[k] = fault_set_i[k];
            end
        end
    endgenerate

    always_comb begin
        stat_d = stat_q;
        for (int k = 0; k < STATUS_W; k++) begin
            // a set pulse takes priority over a write-one clear
            stat_d.bits[k] = set_vec[k] | (stat_q.bits[k] & ~clr_mask[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status_o = stat_q.bits;
    assign alert_o  = |stat_q.bits;

    // R2
    wr_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(stat_q.bits) & ~stat_q.bits) & ~$past(clr_mask)) == '0));

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fault_set_i) & ~stat_q.bits[OVR_BIT-1:0]) == '0));

    // R4
    alert_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_o) |-> ($past(clr_mask) != '0));

endmodule

// File: rtl/fsa_switch_ctrl.sv
module fsa_switch_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl_i,
    input  logic [1:0] wr_data_i,
    input  logic       ovr_det_i,
    input  logic       ovr_pend_i,
    output logic       chg_en_o,
    output logic       dsg_en_o
);

    typedef struct packed {
        logic chg;
        logic dsg;
    } sw_t;

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        if (ovr_det_i) begin
            sw_d = '0;
        end else if (wr_ctrl_i && !ovr_pend_i) begin
            sw_d.chg = wr_data_i[0];
            sw_d.dsg = wr_data_i[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign chg_en_o = sw_q.chg;
    assign dsg_en_o = sw_q.dsg;

    // R6
    ovr_switch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pend_i |-> (!chg_en_o && !dsg_en_o));

    // R8
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && ovr_pend_i) |=> ($stable(chg_en_o) && $stable(dsg_en_o)));

endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
    import fsa_pkg::*;
#(
    parameter int STAT_W     = fsa_pkg::STATUS_W,
    parameter int SYNC_DEPTH = fsa_pkg::SYNC_STAGES,
    parameter int BLANK_LEN  = fsa_pkg::BLANK_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-2:0] fault_set_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              alert_line_i,
    output logic              alert_o,
    output logic [STAT_W-1:0] status_o,
    output logic              chg_en_o,
    output logic              dsg_en_o
);

    localparam int OVR_POS = STAT_W - 1;

    logic ovr_det;
    logic wr_ctrl;

    assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);

    fsa_line_sense #(
        .SYNC_STAGES (SYNC_DEPTH),
        .BLANK_CYCLES(BLANK_LEN)
    ) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_i  (alert_o),
        .line_i   (alert_line_i),
        .ovr_det_o(ovr_det)
    );

    fsa_status_reg #(
        .STATUS_W(STAT_W),
        .OVR_BIT (OVR_POS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_set_i(fault_set_i),
        .ovr_det_i  (ovr_det),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .status_o   (status_o),
        .alert_o    (alert_o)
    );

    fsa_switch_ctrl u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wr_data_i (wr_data_i[1:0]),
        .ovr_det_i (ovr_det),
        .ovr_pend_i(status_o[OVR_POS]),
        .chg_en_o  (chg_en_o),
        .dsg_en_o  (dsg_en_o)
    );

    generate
        if (SYNC_DEPTH == 2 && BLANK_LEN == 1) begin : g_blank_chk
            // R5 R7
            blank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(status_o[OVR_POS]) |-> ($past(!alert_o, 3) && $past(!alert_o, 4)));
        end
    endgenerate

endmodule

// File: tb/fault_alert_ctrl_tb.sv
module fault_alert_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] fault_set = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_hi = 1'b0;
    logic       line;
    logic       alert;
    logic [7:0] status;
    logic       chg_en, dsg_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // wired-OR shared line
    assign line = alert | ext_hi;

    fault_alert_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_set_i (fault_set),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .alert_line_i(line),
        .alert_o     (alert),
        .status_o    (status),
        .chg_en_o    (chg_en),
        .dsg_en_o    (dsg_en)
    );

    // behavioural reference model
    logic [7:0] m_st;
    logic [1:0] m_en;
    int         hl[$];
    int         hd[$];
    int         m_ln, m_dv;
    bit         m_det;
    logic [7:0] m_clr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = '0;
            m_en = '0;
            hl   = '{0, 0, 0, 0};
            hd   = '{0, 0, 0, 0};
        end else begin
            m_dv = (m_st != 0) ? 1 : 0;
            m_ln = (m_dv != 0 || ext_hi) ? 1 : 0;
            hl.push_front(m_ln);
            hd.push_front(m_dv);
            // line two cycles old, drive low then and one cycle before
            m_det = (hl[2] != 0) && (hd[2] == 0) && (hd[3] == 0);
            m_clr = (wr_en && !wr_sel) ? wr_data : 8'h00;
            if (m_det) m_en = 2'b00;
            else if (wr_en && wr_sel && !m_st[7]) m_en = wr_data[1:0];
            m_st = {m_det, fault_set} | (m_st & ~m_clr);
            while (hl.size() > 6) begin
                void'(hl.pop_back());
                void'(hd.pop_back());
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (status !== m_st) begin
                n_fail++;
                $display("FAIL R2 R3 R5 R9 status: actual %02h expected %02h at %0t", status, m_st, $time);
            end
            n_chk++;
            if (alert !== (m_st != 0)) begin
                n_fail++;
                $display("FAIL R1 R4 alert: actual %b expected %b at %0t", alert, (m_st != 0), $time);
            end
            n_chk++;
            if ({dsg_en, chg_en} !== m_en) begin
                n_fail++;
                $display("FAIL R6 R8 enables: actual %b expected %b at %0t", {dsg_en, chg_en}, m_en, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [6:0] v);
        fault_set = v;
        tick(1);
        fault_set = '0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // R9 reset state checked while reset held
        tick(3);
        rst_n = 1'b1;
        tick(4);

        // R3 single and multiple fault pulses, R1 alert follows
        pulse(7'h01);
        tick(3);
        pulse(7'h24);
        tick(2);

        // R2 writing zero changes nothing; partial then full clear, R4
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h01);
        tick(2);
        wr(1'b0, 8'h24);
        tick(3);

        // R3 set and clear on same bit in same cycle: set wins
        fault_set = 7'h08; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h08;
        tick(1);
        fault_set = '0; wr_en = 1'b0; wr_data = '0;
        tick(2);
        wr(1'b0, 8'h08);
        tick(2);

        // R8 switch enable writes
        wr(1'b1, 8'h03);
        tick(2);
        wr(1'b1, 8'h01);
        tick(2);
        wr(1'b1, 8'h03);
        tick(2);

        // R5 one-cycle external high while drive low, R6 enables drop
        ext_hi = 1'b1;
        tick(1);
        ext_hi = 1'b0;
        tick(6);

        // R8 enable write ignored while override pending
        wr(1'b1, 8'h03);
        tick(2);
        wr(1'b0, 8'h80);
        tick(2);
        wr(1'b1, 8'h03);
        tick(3);

        // R7 external high while driving high, and in the cycle after drive falls
        pulse(7'h02);
        tick(2);
        ext_hi = 1'b1;
        tick(5);
        wr(1'b0, 8'h02);
        tick(1);
        ext_hi = 1'b0;
        tick(6);

        // R5 external high held across the drive fall is caught once blank ends
        pulse(7'h10);
        tick(1);
        ext_hi = 1'b1;
        tick(2);
        wr(1'b0, 8'h10);
        tick(4);
        ext_hi = 1'b0;
        tick(4);
        wr(1'b0, 8'hFF);
        tick(3);

        // mixed pseudo-random traffic covering all requirements
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fault_set = (lfsr[3:0] == 4'h0) ? lfsr[10:4] : 7'h00;
            ext_hi    = (lfsr[7:4] == 4'h5) || (lfsr[7:4] == 4'h6);
            wr_en     = lfsr[12];
            wr_sel    = lfsr[13] & lfsr[14];
            wr_data   = {lfsr[2], lfsr[15:9]};
            tick(1);
        end
        fault_set = '0; ext_hi = 1'b0; wr_en = 1'b0;
        tick(5);
        finish_run();
    end

endmodule